// File: doc/BRIEF.md
# Row-Ordered Pixel Delta Encoder

This block takes the hits of one detector region for one event and re-emits them as a stream of position differences. Hits arrive grouped by column. Each hit carries a column, a row and a 5-bit pulse-height value. A separate end-of-event beat closes the event. The block keeps the hits sorted as they arrive. Once the event has closed, it drains them in row-major order, with columns increasing within a row. For each hit it outputs the signed column and row differences from the hit emitted before it. The first hit of every event is measured from the origin (0, 0). Each output tuple also carries the hit's own pulse-height value, so that three separate downstream entropy coders can each take one field.

A full sensor is split into four such regions that run in parallel, and each region accepts at most 100 hits per event. Column coordinates within a region fit in 8 bits and row coordinates fit in 10 bits. Sending hits in row order keeps the row differences mostly at zero and the column differences small, which lowers the entropy of the position fields. The input is held off while an event drains. Both sides use valid/ready handshakes.

Top module: `pde_top`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The data tuples of an event come out sorted by row ascending and, within a row, by column ascending. The running sum of the differences gives each hit's absolute (column, row).
- R3: For every data tuple after the first, `out_dx` is column minus the previous column and `out_dy` is row minus the previous row. Both are two's-complement values, 9 and 11 bits wide.
- R4: The first data tuple of each event takes its differences from column 0 and row 0, whatever the previous event held.
- R5: `out_adc` equals the pulse-height value that arrived with the hit the tuple describes.
- R6: A marker beat (`out_eoe`=1, with `out_dx`, `out_dy` and `out_adc` all 0) follows the last data tuple of each event. An event with no hits yields only the marker. Data tuples have `out_eoe`=0.
- R7: Hits beyond the 100th in one event are dropped. `out_ovf` is 1 on that event's marker and 0 on every other beat, including the next event's marker.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R9: After an end-of-event beat is accepted, `in_ready` stays 0 until the marker is taken. Input offered in that interval is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_eoe | input | 1 | Beat is an end-of-event marker with no hit |
| in_col | input | 8 | Hit column within the region |
| in_row | input | 10 | Hit row within the region |
| in_adc | input | 5 | Hit pulse height |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_eoe | output | 1 | Output beat is the end-of-event marker |
| out_ovf | output | 1 | Hits were dropped in this event (marker only) |
| out_dx | output | 9 | Signed column difference |
| out_dy | output | 11 | Signed row difference |
| out_adc | output | 5 | Pulse height of the hit |

## Verification
The encoder is fed several kinds of event. The first is column-grouped, with several hits sharing rows, which shows whether the block truly sorts by row and not by arrival. Another places hits in one row in reverse column order, which exercises the tie-break on column. Hits at opposite corners of the region produce the largest positive and negative differences and test the sign widths. Empty events, a 105-hit event followed by a small one, and a stall with junk input during the drain separate the marker, the overflow and its clearing, output hold, and input blocking.

// File: rtl/pde_pkg.sv
`timescale 1ns/1ps
package pde_pkg;

    localparam int COL_W = 8;
    localparam int ROW_W = 10;
    localparam int ADC_W = 5;
    localparam int DX_W  = COL_W + 1;
    localparam int DY_W  = ROW_W + 1;
    localparam int KEY_W = ROW_W + COL_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ADC_W-1:0] adc;
    } hit_t;

    typedef struct packed {
        logic signed [DX_W-1:0] dx;
        logic signed [DY_W-1:0] dy;
        logic [ADC_W-1:0]       adc;
    } delta_t;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_DRAIN   = 2'd1,
        PH_MARK    = 2'd2
    } phase_e;

    // Row-major sort key: row is the major field, column the minor one.
    function automatic logic [KEY_W-1:0] hit_key(hit_t h);
        return {h.row, h.col};
    endfunction

    function automatic delta_t make_delta(hit_t cur,
                                          logic [COL_W-1:0] prev_col,
                                          logic [ROW_W-1:0] prev_row);
        delta_t d;
        d.dx  = $signed({1'b0, cur.col}) - $signed({1'b0, prev_col});
        d.dy  = $signed({1'b0, cur.row}) - $signed({1'b0, prev_row});
        d.adc = cur.adc;
        return d;
    endfunction

endpackage

// File: rtl/pde_sort_slots.sv
`timescale 1ns/1ps
// Keeps the hits of one event in row-major order. Each cycle one new hit is
// placed at its sorted position, and every slot holding a larger key moves
// up by one.
module pde_sort_slots
    import pde_pkg::*;
#(
    parameter int DEPTH = 100,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             ins_en,
    input  hit_t             ins_hit,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] rd_sel,
    output hit_t             rd_hit
);

    hit_t             slot_q [DEPTH];
    logic [DEPTH-1:0] used;
    logic [DEPTH-1:0] above;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign used[i]  = CNT_W'(i) < fill;
        assign above[i] = used[i] && (hit_key(slot_q[i]) > hit_key(ins_hit));

        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (ins_en && (above[0] || !used[0])) begin
                    slot_q[0] <= ins_hit;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (ins_en) begin
                    if (above[i-1]) begin
                        slot_q[i] <= slot_q[i-1];
                    end else if (above[i] || !used[i]) begin
                        slot_q[i] <= ins_hit;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_hit = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (CNT_W'(k) == rd_sel) begin
                rd_hit = slot_q[k];
            end
        end
    end

endmodule

// File: rtl/pde_delta_calc.sv
`timescale 1ns/1ps
// Holds the position of the last emitted hit and forms the signed differences.
module pde_delta_calc
    import pde_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   step,
    input  hit_t   cur_hit,
    output delta_t delta
);

    logic [COL_W-1:0] prev_col_q;
    logic [ROW_W-1:0] prev_row_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            prev_col_q <= '0;
            prev_row_q <= '0;
        end else if (step) begin
            prev_col_q <= cur_hit.col;
            prev_row_q <= cur_hit.row;
        end
    end

    assign delta = make_delta(cur_hit, prev_col_q, prev_row_q);

endmodule

// File: rtl/pde_top.sv
`timescale 1ns/1ps
module pde_top
    import pde_pkg::*;
#(
    parameter int MAX_HITS = 100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_eoe,
    input  logic [COL_W-1:0]        in_col,
    input  logic [ROW_W-1:0]        in_row,
    input  logic [ADC_W-1:0]        in_adc,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_eoe,
    output logic                    out_ovf,
    output logic signed [DX_W-1:0]  out_dx,
    output logic signed [DY_W-1:0]  out_dy,
    output logic [ADC_W-1:0]        out_adc
);

    localparam int CNT_W = $clog2(MAX_HITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_HITS);

    phase_e           phase_q;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] rd_q;
    logic             ovf_q;

    hit_t   new_hit;
    hit_t   cur_hit;
    delta_t cur_delta;

    logic take, take_hit, take_end, store, fire, last_rd;

    assign new_hit   = '{row: in_row, col: in_col, adc: in_adc};
    assign in_ready  = (phase_q == PH_COLLECT);
    assign out_valid = (phase_q != PH_COLLECT);

    assign take      = in_valid && in_ready;
    assign take_hit  = take && !in_eoe;
    assign take_end  = take && in_eoe;
    assign store     = take_hit && (fill_q != FULL);
    assign fire      = out_valid && out_ready;
    assign last_rd   = (rd_q == fill_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COLLECT;
            fill_q  <= '0;
            rd_q    <= '0;
            ovf_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_COLLECT: begin
                    if (store) begin
                        fill_q <= fill_q + CNT_W'(1);
                    end
                    if (take_hit && (fill_q == FULL)) begin
                        ovf_q <= 1'b1;
                    end
                    if (take_end) begin
                        rd_q    <= '0;
                        phase_q <= (fill_q == '0) ? PH_MARK : PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    if (fire) begin
                        rd_q <= rd_q + CNT_W'(1);
                        if (last_rd) begin
                            phase_q <= PH_MARK;
                        end
                    end
                end
                PH_MARK: begin
                    if (fire) begin
                        phase_q <= PH_COLLECT;
                        fill_q  <= '0;
                        ovf_q   <= 1'b0;
                    end
                end
                default: phase_q <= PH_COLLECT;
            endcase
        end
    end

    pde_sort_slots #(
        .DEPTH (MAX_HITS),
        .CNT_W (CNT_W)
    ) sort_i (
        .clk     (clk),
        .ins_en  (store),
        .ins_hit (new_hit),
        .fill    (fill_q),
        .rd_sel  (rd_q),
        .rd_hit  (cur_hit)
    );

    pde_delta_calc delta_i (
        .clk     (clk),
        .rst     (rst),
        .restart (fire && (phase_q == PH_MARK)),
        .step    (fire && (phase_q == PH_DRAIN)),
        .cur_hit (cur_hit),
        .delta   (cur_delta)
    );

    always_comb begin
        out_eoe = 1'b0;
        out_ovf = 1'b0;
        out_dx  = '0;
        out_dy  = '0;
        out_adc = '0;
        if (phase_q == PH_DRAIN) begin
            out_dx  = cur_delta.dx;
            out_dy  = cur_delta.dy;
            out_adc = cur_delta.adc;
        end else if (phase_q == PH_MARK) begin
            out_eoe = 1'b1;
            out_ovf = ovf_q;
        end
    end

endmodule

// File: rtl/pde_check.sv
`timescale 1ns/1ps
module pde_check
    import pde_pkg::*;
#(
    parameter int MAX_HITS = 100,
    parameter int CNT_W    = $clog2(MAX_HITS + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   in_eoe,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic                   out_eoe,
    input logic                   out_ovf,
    input logic signed [DX_W-1:0] out_dx,
    input logic signed [DY_W-1:0] out_dy,
    input logic [ADC_W-1:0]       out_adc,
    input logic [CNT_W-1:0]       fill_q
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    assert_row_order_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eoe) |-> !out_dy[DY_W-1]);

    assert_col_order_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eoe && out_dy == '0) |-> !out_dx[DX_W-1]);

    assert_marker_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eoe) |=> out_valid);

    assert_marker_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eoe) |=> (in_ready && !out_valid));

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CNT_W'(MAX_HITS));

    assert_ovf_on_marker_R7: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_valid && out_eoe));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dx) && $stable(out_dy)
            && $stable(out_adc) && $stable(out_eoe) && $stable(out_ovf)));

    assert_block_input_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_eoe) |=> !in_ready);

endmodule

bind pde_top pde_check #(.MAX_HITS(MAX_HITS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eoe    (in_eoe),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_eoe   (out_eoe),
    .out_ovf   (out_ovf),
    .out_dx    (out_dx),
    .out_dy    (out_dy),
    .out_adc   (out_adc),
    .fill_q    (fill_q)
);

// File: tb/pde_top_tb_top.sv
`timescale 1ns/1ps
module pde_top_tb_top;
    import pde_pkg::*;

    localparam int MAXH  = 100;
    localparam int NVEC  = 16;
    // Vector fields: {end-of-event, column[7:0], row[9:0], adc[4:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 8'd2,   10'd5,   5'd3},
        {1'b0, 8'd2,   10'd1,   5'd7},
        {1'b0, 8'd4,   10'd1,   5'd9},
        {1'b0, 8'd4,   10'd5,   5'd1},
        {1'b0, 8'd7,   10'd0,   5'd31},
        {1'b1, 8'd0,   10'd0,   5'd0},
        {1'b1, 8'd0,   10'd0,   5'd0},
        {1'b0, 8'd200, 10'd600, 5'd17},
        {1'b1, 8'd0,   10'd0,   5'd0},
        {1'b0, 8'd255, 10'd0,   5'd4},
        {1'b0, 8'd0,   10'd647, 5'd0},
        {1'b1, 8'd0,   10'd0,   5'd0},
        {1'b0, 8'd9,   10'd3,   5'd12},
        {1'b0, 8'd3,   10'd3,   5'd6},
        {1'b0, 8'd9,   10'd2,   5'd8},
        {1'b1, 8'd0,   10'd0,   5'd0}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic                   in_eoe = 1'b0;
    logic [COL_W-1:0]       in_col = '0;
    logic [ROW_W-1:0]       in_row = '0;
    logic [ADC_W-1:0]       in_adc = '0;
    logic                   out_valid;
    logic                   out_ready = 1'b0;
    logic                   out_eoe;
    logic                   out_ovf;
    logic signed [DX_W-1:0] out_dx;
    logic signed [DY_W-1:0] out_dy;
    logic [ADC_W-1:0]       out_adc;

    pde_top #(.MAX_HITS(MAXH)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
        .in_col(in_col), .in_row(in_row), .in_adc(in_adc),
        .out_valid(out_valid), .out_ready(out_ready), .out_eoe(out_eoe),
        .out_ovf(out_ovf), .out_dx(out_dx), .out_dy(out_dy), .out_adc(out_adc)
    );

    int n_total = 0;
    int n_fail  = 0;

    int mc [128];
    int mr [128];
    int ma [128];
    int mn   = 0;
    bit movf = 1'b0;

    task automatic chk(string req, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(bit e, int c, int r, int a);
        in_eoe   = e;
        in_col   = COL_W'(c);
        in_row   = ROW_W'(r);
        in_adc   = ADC_W'(a);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic model_hit(int c, int r, int a);
        if (mn < MAXH) begin
            mc[mn] = c; mr[mn] = r; ma[mn] = a;
            mn++;
        end else begin
            movf = 1'b1;
        end
    endtask

    task automatic model_sort();
        for (int i = 0; i < mn; i++) begin
            for (int j = 0; j + 1 < mn - i; j++) begin
                if (mr[j] * 1024 + mc[j] > mr[j+1] * 1024 + mc[j+1]) begin
                    int t;
                    t = mc[j]; mc[j] = mc[j+1]; mc[j+1] = t;
                    t = mr[j]; mr[j] = mr[j+1]; mr[j+1] = t;
                    t = ma[j]; ma[j] = ma[j+1]; ma[j+1] = t;
                end
            end
        end
    endtask

    task automatic get_beat(bit stall, output int dx, output int dy,
                            output int adc, output int eoe, output int ovf);
        if (stall) begin
            out_ready = 1'b0;
            while (!out_valid) @(negedge clk);
            dx = int'(out_dx); dy = int'(out_dy); adc = int'(out_adc);
            in_eoe = 1'b0; in_col = 8'd50; in_row = 10'd50; in_adc = 5'd5;
            in_valid = 1'b1;
            repeat (3) @(negedge clk);
            chk("R8 dx hold", int'(out_dx), dx);
            chk("R8 dy hold", int'(out_dy), dy);
            chk("R8 adc hold", int'(out_adc), adc);
            chk("R8 valid hold", int'(out_valid), 1);
            chk("R9 input blocked", int'(in_ready), 0);
            in_valid = 1'b0;
        end
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        chk("R9 in_ready low while draining", int'(in_ready), 0);
        dx  = int'(out_dx);
        dy  = int'(out_dy);
        adc = int'(out_adc);
        eoe = int'(out_eoe);
        ovf = int'(out_ovf);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic drain_check(bit stall);
        int px, py, ax, ay, dx, dy, adc, eoe, ovf;
        model_sort();
        px = 0; py = 0; ax = 0; ay = 0;
        for (int k = 0; k < mn; k++) begin
            get_beat(stall && (k == 1), dx, dy, adc, eoe, ovf);
            chk("R6 data beat eoe", eoe, 0);
            if (k == 0) begin
                chk("R4 first dx from origin", dx, mc[k]);
                chk("R4 first dy from origin", dy, mr[k]);
            end else begin
                chk("R3 dx", dx, mc[k] - px);
                chk("R3 dy", dy, mr[k] - py);
            end
            chk("R5 adc", adc, ma[k]);
            ax += dx; ay += dy;
            chk("R2 column position", ax, mc[k]);
            chk("R2 row position", ay, mr[k]);
            chk("R7 ovf low on data", ovf, 0);
            px = mc[k]; py = mr[k];
        end
        get_beat(1'b0, dx, dy, adc, eoe, ovf);
        chk("R6 marker eoe", eoe, 1);
        chk("R6 marker fields zero", dx | dy | adc, 0);
        chk("R7 marker ovf", ovf, int'(movf));
        mn = 0;
        movf = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int ev;
        ev = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        chk("R1 out_valid after reset", int'(out_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] w;
            w = VEC[v];
            if (w[23]) begin
                send(1'b1, 0, 0, 0);
                drain_check(ev == 0);
                ev++;
            end else begin
                send(1'b0, int'(w[22:15]), int'(w[14:5]), int'(w[4:0]));
                model_hit(int'(w[22:15]), int'(w[14:5]), int'(w[4:0]));
            end
        end

        // R7: overflow, then an event that must report no overflow
        for (int i = 0; i < 105; i++) begin
            send(1'b0, i, (i * 37) % 600, i % 32);
            model_hit(i, (i * 37) % 600, i % 32);
        end
        send(1'b1, 0, 0, 0);
        drain_check(1'b0);

        send(1'b0, 11, 13, 21);
        model_hit(11, 13, 21);
        send(1'b1, 0, 0, 0);
        drain_check(1'b0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule